// File: doc/BRIEF.md
# Four-Channel DAC Code Update Controller

This block keeps the output codes of four digital-to-analog converter channels and decides in which clock cycle each channel's active code changes. Software writes arrive on a simple register-write port: a 4-bit address, 16-bit data and a write enable. Each channel owns two registers. The buffer register receives new codes. The active register drives the converter. A per-channel mode bit picks between two update styles. In immediate mode a write reaches the active register at once. In deferred mode the write waits in the buffer until a falling edge on the external active-low load input. A broadcast address writes one code to every channel that is enabled for broadcast.

Three strap inputs set the state after reset: the reset code (zero scale or midscale), the output gain (x1 or x2) and the reference divider (÷1 or ÷2). The straps are sampled only while the controller passes through its initialisation state. That state is entered after the power-on reset input is released, and again after a software reset command. Changing a strap at any other time has no effect.

The controller is a two-state machine. State INIT loads the strap-derived values, the channel codes and the default mode register. It is left unconditionally on the next clock for state RUN (transition INIT→RUN). RUN accepts register writes. It stays in RUN (RUN→RUN) except on a valid software-reset write, which returns it to INIT (RUN→INIT). The power-on reset forces INIT from any state.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset release the block spends one cycle in INIT. After that clock edge, every active code equals 0x8000 when `strap_midscale` is 1 and 0x0000 when it is 0, `gain_x2` equals `strap_gain2`, `ref_div2` equals `strap_refdiv2`, and the mode register holds 0xFF00.
- R2: In RUN, changes on the three strap inputs leave `gain_x2`, `ref_div2` and the channel codes unchanged.
- R3: A write to address 0x8+n (n = 0..3) targets channel n. Writes to addresses 0xC to 0xF change no channel.
- R4: A write to a channel whose mode bit n (bit n of the mode register) is 0 updates both its buffer and its active code at the same clock edge.
- R5: A write to a channel whose mode bit n is 1 updates only its buffer. Its active code stays unchanged until a load edge.
- R6: `load_n` passes through two synchroniser flops. A high-to-low change seen before clock edge e copies the buffer to the active code of every mode-1 channel together at edge e+2. Mode-0 channels ignore the edge.
- R7: When a write to a mode-1 channel lands at the same edge as the load copy, the active code takes the newly written data.
- R8: A write to address 0x6 writes its data to every channel whose broadcast-enable bit (mode register bit 8+n) is 1. Each such channel then follows R4 or R5 according to its mode bit. Channels whose broadcast-enable bit is 0 are untouched.
- R9: A write to address 0x5 with data bits [3:0] = 0xA moves the block to INIT at the next edge, which restores the full power-on state, straps re-sampled. Other data values at 0x5 have no effect.
- R10: With `load_n` held low permanently, mode-0 channels still update through writes.
- R11: Address 0x2 writes the mode register. Bits [3:0] are the per-channel mode bits and bits [11:8] the per-channel broadcast enables. A new value governs writes from the next edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| load_n | input | 1 | Asynchronous active-low load input; falling edge updates mode-1 channels |
| strap_midscale | input | 1 | Reset-code strap: 1 = midscale, 0 = zero scale |
| strap_gain2 | input | 1 | Gain strap sampled in INIT: 1 = gain of 2 |
| strap_refdiv2 | input | 1 | Reference-divider strap sampled in INIT: 1 = divide by 2 |
| act_codes | output | 64 | Active codes, channel n in bits [16n+15:16n] |
| gain_x2 | output | 1 | Latched gain setting |
| ref_div2 | output | 1 | Latched reference-divider setting |

## Verification
The hardest case to reach from the ports is a channel write that lands in exactly the cycle in which the synchronised load edge fires (R7). The load input crosses two flops and an edge detector before it acts. The stimulus therefore drops `load_n` and then places the channel write two clocks later, so the write and the load copy share one edge. A long stretch of random writes, mode changes and load toggles follows. A behavioural model is compared against the design on every clock, so coincidences between broadcast writes, mode changes and load edges are covered as well.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

    typedef enum logic [0:0] {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } upd_state_e;

    localparam int ADDR_MODE     = 2;
    localparam int ADDR_SOFTRST  = 5;
    localparam int ADDR_BCAST    = 6;
    localparam int ADDR_CH_BASE  = 8;
    localparam int SOFTRST_KEY   = 10;
    localparam int MODE_RESET    = 16'hFF00;

endpackage

// File: rtl/dac_load_sync.sv
module dac_load_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic load_n,
    output logic fall_pulse
);

    logic [2:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= 3'b111;
        end else begin
            sh_q <= {sh_q[1:0], load_n};
        end
    end

    assign fall_pulse = sh_q[2] & ~sh_q[1];

    // R6: a detected edge lasts exactly one cycle
    assert_fall_single_R6: assert property (
        @(posedge clk) disable iff (!rst_n) fall_pulse |=> !fall_pulse
    );

endmodule

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
    import dac_upd_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 4,
    parameter int DW  = 16
) (
    input  logic           wr_en,
    input  logic           accept,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [NCH-1:0] bcast_en,
    output logic [NCH-1:0] chan_wr,
    output logic           mode_wr,
    output logic           soft_rst
);

    logic           take;
    logic           bcast_hit;
    logic [NCH-1:0] direct_hit;

    assign take      = wr_en & accept;
    assign bcast_hit = take & (wr_addr == AW'(ADDR_BCAST));
    assign mode_wr   = take & (wr_addr == AW'(ADDR_MODE));
    assign soft_rst  = take & (wr_addr == AW'(ADDR_SOFTRST))
                     & (wr_data[3:0] == 4'(SOFTRST_KEY));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign direct_hit[g] = take & (wr_addr == AW'(ADDR_CH_BASE + g));
        assign chan_wr[g]    = direct_hit[g] | (bcast_hit & bcast_en[g]);
    end

    // R3: a direct write selects at most one channel and never a control register
    always_comb begin
        assert_one_target_R3: assert ($onehot0({|direct_hit, bcast_hit, mode_wr, soft_rst}) && $onehot0(direct_hit));
    end

endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic [DW-1:0] init_code,
    input  logic          wr,
    input  logic [DW-1:0] wr_val,
    input  logic          sync_mode,
    input  logic          load,
    output logic [DW-1:0] buf_code,
    output logic [DW-1:0] act_code
);

    logic [DW-1:0] buf_next;

    assign buf_next = wr ? wr_val : buf_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_code <= '0;
            act_code <= '0;
        end else if (init) begin
            buf_code <= init_code;
            act_code <= init_code;
        end else begin
            buf_code <= buf_next;
            if ((wr && !sync_mode) || (load && sync_mode)) begin
                act_code <= buf_next;
            end
        end
    end

    assert_init_load_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        init |=> (act_code == $past(init_code)) && (buf_code == $past(init_code))
    );

    assert_async_write_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!init && wr && !sync_mode) |=> act_code == $past(wr_val)
    );

    assert_sync_hold_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!init && sync_mode && !load) |=> $stable(act_code)
    );

    assert_load_copy_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!init && sync_mode && load && !wr) |=> act_code == $past(buf_code)
    );

    assert_load_new_data_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!init && sync_mode && load && wr) |=> act_code == $past(wr_val)
    );

endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dac_upd_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int AW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              load_n,
    input  logic              strap_midscale,
    input  logic              strap_gain2,
    input  logic              strap_refdiv2,
    output logic [NCH*DW-1:0] act_codes,
    output logic              gain_x2,
    output logic              ref_div2
);

    localparam int BC_LSB = DW / 2;
    localparam logic [DW-1:0] MID_CODE  = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] ZERO_CODE = '0;

    upd_state_e     state_q, state_d;
    logic [DW-1:0]  mode_q;
    logic           in_init;
    logic           load_pulse;
    logic [NCH-1:0] chan_wr;
    logic           mode_wr;
    logic           soft_rst;
    logic [DW-1:0]  init_code;

    assign in_init   = (state_q == ST_INIT);
    assign init_code = strap_midscale ? MID_CODE : ZERO_CODE;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: INIT->RUN always, RUN->INIT on software reset
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: state_d = ST_RUN;
            ST_RUN:  state_d = soft_rst ? ST_INIT : ST_RUN;
            default: state_d = ST_INIT;
        endcase
    end

    // outputs held by the state machine: straps and mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= DW'(MODE_RESET);
            gain_x2  <= 1'b0;
            ref_div2 <= 1'b0;
        end else if (in_init) begin
            mode_q   <= DW'(MODE_RESET);
            gain_x2  <= strap_gain2;
            ref_div2 <= strap_refdiv2;
        end else if (mode_wr) begin
            mode_q   <= wr_data;
        end
    end

    dac_load_sync u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_n     (load_n),
        .fall_pulse (load_pulse)
    );

    dac_wr_decode #(.NCH(NCH), .AW(AW), .DW(DW)) u_dec (
        .wr_en    (wr_en),
        .accept   (!in_init),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .bcast_en (mode_q[BC_LSB +: NCH]),
        .chan_wr  (chan_wr),
        .mode_wr  (mode_wr),
        .soft_rst (soft_rst)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [DW-1:0] buf_code;
        dac_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .init      (in_init),
            .init_code (init_code),
            .wr        (chan_wr[c]),
            .wr_val    (wr_data),
            .sync_mode (mode_q[c]),
            .load      (load_pulse),
            .buf_code  (buf_code),
            .act_code  (act_codes[c*DW +: DW])
        );
    end

    assert_init_exit_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        in_init |=> (state_q == ST_RUN) && (mode_q == DW'(MODE_RESET))
    );

    assert_strap_hold_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(gain_x2) && $stable(ref_div2)
    );

    assert_soft_reset_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        soft_rst |=> in_init
    );

    assert_mode_write_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        mode_wr |=> mode_q == $past(wr_data)
    );

endmodule

// File: tb/tb_dac_update_ctrl.sv
module tb_dac_update_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        load_n = 1'b1;
    logic        strap_midscale = 1'b1;
    logic        strap_gain2 = 1'b1;
    logic        strap_refdiv2 = 1'b0;
    logic [63:0] act_codes;
    logic        gain_x2;
    logic        ref_div2;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit cmp_on  = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    dac_update_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_n(load_n), .strap_midscale(strap_midscale),
        .strap_gain2(strap_gain2), .strap_refdiv2(strap_refdiv2),
        .act_codes(act_codes), .gain_x2(gain_x2), .ref_div2(ref_div2)
    );

    // behavioural reference model
    int        m_buf [4];
    int        m_act [4];
    int        m_mode;
    bit        m_init;
    bit        m_gain, m_refd;
    bit [2:0]  m_hist;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_init = 1; m_mode = 'hFF00; m_gain = 0; m_refd = 0; m_hist = 3'b111;
            foreach (m_act[i]) begin m_act[i] = 0; m_buf[i] = 0; end
        end else begin
            bit fall;
            int new_mode;
            fall = m_hist[2] && !m_hist[1];
            m_hist = {m_hist[1:0], load_n};
            new_mode = m_mode;
            if (m_init) begin
                foreach (m_act[i]) begin
                    m_act[i] = strap_midscale ? 'h8000 : 0;
                    m_buf[i] = m_act[i];
                end
                m_mode = 'hFF00; m_gain = strap_gain2; m_refd = strap_refdiv2;
                m_init = 0;
            end else begin
                if (wr_en) begin
                    for (int c = 0; c < 4; c++) begin
                        if (int'(wr_addr) == 8 + c || (wr_addr == 4'd6 && m_mode[8+c])) begin
                            m_buf[c] = wr_data;
                            if (!m_mode[c]) m_act[c] = wr_data;
                        end
                    end
                    if (wr_addr == 4'd2) new_mode = wr_data;
                    if (wr_addr == 4'd5 && wr_data[3:0] == 4'hA) m_init = 1;
                end
                for (int c = 0; c < 4; c++)
                    if (fall && m_mode[c]) m_act[c] = m_buf[c];
                m_mode = new_mode;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit bad;
            bad = (gain_x2 != m_gain) || (ref_div2 != m_refd);
            for (int c = 0; c < 4; c++)
                if (int'(act_codes[c*16 +: 16]) != m_act[c]) bad = 1;
            n_tests++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s model: codes=%h gain=%0d div=%0d expected %h_%h_%h_%h gain=%0d div=%0d",
                         cur_req, act_codes, gain_x2, ref_div2, m_act[3][15:0], m_act[2][15:0],
                         m_act[1][15:0], m_act[0][15:0], m_gain, m_refd);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int code(int c);
        return int'(act_codes[c*16 +: 16]);
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        cmp_on = 1;
        chk("R1 reset code", code(0), 0);
        rst_n = 1;
        tick(2);
        cur_req = "R1";
        for (int c = 0; c < 4; c++) chk("R1 midscale", code(c), 'h8000);
        chk("R1 gain", gain_x2, 1);
        chk("R1 refdiv", ref_div2, 0);

        cur_req = "R2";
        strap_gain2 = 0; strap_refdiv2 = 1; strap_midscale = 0;
        tick(4);
        chk("R2 gain held", gain_x2, 1);
        chk("R2 refdiv held", ref_div2, 0);

        cur_req = "R4";
        wr(4'h8, 16'h1234);
        chk("R4 async ch0", code(0), 'h1234);

        cur_req = "R3";
        wr(4'hC, 16'hDEAD);
        wr(4'hF, 16'hDEAD);
        chk("R3 ch3 untouched", code(3), 'h8000);
        chk("R3 ch0 untouched", code(0), 'h1234);

        cur_req = "R5";
        wr(4'h2, 16'hFF05);
        wr(4'h8, 16'hAAAA);
        wr(4'hA, 16'h5555);
        wr(4'h9, 16'h1111);
        chk("R5 ch0 held", code(0), 'h1234);
        chk("R5 ch2 held", code(2), 'h8000);
        chk("R11 ch1 async", code(1), 'h1111);

        cur_req = "R6";
        load_n = 0;
        tick(2);
        chk("R6 not yet", code(0), 'h1234);
        tick();
        chk("R6 ch0 loaded", code(0), 'hAAAA);
        chk("R6 ch2 loaded", code(2), 'h5555);
        chk("R6 ch1 unaffected", code(1), 'h1111);

        cur_req = "R7";
        load_n = 1;
        tick(4);
        wr(4'hA, 16'h6666);
        load_n = 0;
        tick(2);
        wr(4'hA, 16'h7777);
        chk("R7 new data on edge", code(2), 'h7777);
        chk("R7 ch0 reloaded", code(0), 'hAAAA);
        load_n = 1;
        tick(3);

        cur_req = "R8";
        wr(4'h2, 16'h0500);
        wr(4'h6, 16'h4242);
        chk("R8 ch0 bcast", code(0), 'h4242);
        chk("R8 ch2 bcast", code(2), 'h4242);
        chk("R8 ch1 excluded", code(1), 'h1111);
        chk("R8 ch3 excluded", code(3), 'h8000);

        cur_req = "R10";
        load_n = 0;
        tick(5);
        wr(4'hB, 16'hBEEF);
        chk("R10 async with load low", code(3), 'hBEEF);

        cur_req = "R9";
        wr(4'h5, 16'h0003);
        chk("R9 wrong key ignored", code(3), 'hBEEF);
        chk("R9 wrong key gain", gain_x2, 1);
        wr(4'h5, 16'h000A);
        tick();
        for (int c = 0; c < 4; c++) chk("R9 reset code", code(c), 0);
        chk("R9 gain resampled", gain_x2, 0);
        chk("R9 refdiv resampled", ref_div2, 1);
        wr(4'h9, 16'h0101);
        chk("R9 mode restored async", code(1), 'h0101);

        cur_req = "R6 random";
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            wr_en   = (r < 45);
            wr_addr = 4'($urandom_range(0, 15));
            wr_data = 16'($urandom);
            if (wr_addr == 4'h2) wr_data[15:12] = 4'h0;
            if (r > 90) load_n = ~load_n;
            if (r == 99) strap_midscale = ~strap_midscale;
            tick();
        end
        wr_en = 0;
        tick(4);
        finish_run();
    end

endmodule